// File: doc/BRIEF.md
# Debug Console Serial Port

This block is a full-duplex asynchronous serial port for a debug console. It sits behind a small register window on a simple single-cycle bus and keeps one byte in flight in each direction. Software writes a byte to either of two transmit-data addresses to send it. It polls a busy flag, or waits for the transmit-complete interrupt, before sending the next byte. The receiver oversamples the line at sixteen times the bit rate and lands each frame in a single-entry buffer. Parity, framing and overrun problems are recorded in sticky status flags.

The bit rate comes from an integer divisor. One oversampling tick occurs every `divisor` clocks, and a divisor of 0 acts as 1, so one bit lasts `16 * divisor` clocks. A frame is one low start bit, eight data bits with the least significant bit first, an optional parity bit, and one high stop bit. Both directions use the same parity setting.

Register addresses are word indices on `bus_addr`:
- 0: status.
- 1 and 2: transmit data.
- 3: receive data. A read of this address marks the buffer as consumed.
- 4: control.
- 5: divisor.
- 6: interrupt status.

Top module: `dbg_uart`

## Requirements
- R1: The status register (address 0) has the transmit-busy flag at bit 7, the parity error at bit 2, the framing error at bit 1 and the overrun at bit 0. Bits 15:8 and 6:3 always read 0.
- R2: After reset, every status bit, the interrupt-status bit, `irq` and the receive buffer read 0, and `tx_out` idles high.
- R3: A write to address 1 or to address 2 while the port is idle sets the busy flag on the next clock. It then sends the low byte of the write as a frame: 0 start bit, data bits 0 to 7, parity (if enabled), then a 1 stop bit. Each bit lasts 16 ticks. `tx_out` is high whenever the port is not busy.
- R4: When the stop bit ends, the busy flag clears and bit 0 of the interrupt-status register (address 6) is set in the same cycle. `irq` follows that bit. Writing 1 to that bit clears it.
- R5: A write to either transmit-data address while busy is ignored. The byte already in flight is sent unchanged, and no second frame follows.
- R6: A received frame places its data byte in bits 7:0 of address 3.
- R7: Control (address 4) bit 0 enables parity, and bit 1 selects odd parity (0 selects even). A received parity bit that does not match sets the parity error flag.
- R8: A stop bit sampled low sets the framing error flag. The byte is still stored.
- R9: A frame that completes while the buffer holds an unread byte sets the overrun flag and replaces the stored byte with the newer one.
- R10: The error flags stay set until software writes 1 to their own bit of address 0. Writing 1 to one flag's bit leaves the other flags unchanged.
- R11: The divisor (address 5) sets the tick period in clocks. A value of 0 acts as 1.
- R12: A low pulse on `rx_in` that does not last to the middle of the start bit (8 ticks) is discarded. No frame is received and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| rx_in | input | 1 | Serial receive line |
| tx_out | output | 1 | Serial transmit line |
| irq | output | 1 | Transmit-complete interrupt, active high |

## Verification
Each result is due at a different time:
- Register reads are combinational, so the bench samples `bus_rdata` 1 ns after it drives the address, on a falling clock edge.
- The busy flag is due one clock after a transmit write.
- The transmitted frame is sampled at the centre of each bit. Sampling starts half a bit period after the write edge and then steps one bit period at a time. This tolerates the phase offset of up to one tick between the write and the first tick.
- Received data, error flags and `irq` are read only after the bench has held the line idle for one further bit period after the stop bit. This covers the two-flop input synchroniser and the centre sampling point of the stop bit.

// File: rtl/dbg_uart_pkg.sv
package dbg_uart_pkg;
  localparam int BYTE_W = 8;
  localparam int OVS    = 16;
  localparam int HALF   = OVS / 2;
  localparam int CNT_W  = $clog2(OVS);
  localparam int FRM_W  = BYTE_W + 3;
  localparam int BIT_W  = $clog2(FRM_W);
  localparam int REG_AW = 3;
  localparam int REG_DW = 16;

  localparam int ST_BUSY = 7;
  localparam int ST_PE   = 2;
  localparam int ST_FE   = 1;
  localparam int ST_OV   = 0;

  typedef enum logic [REG_AW-1:0] {
    A_STAT = 3'd0,
    A_TXA  = 3'd1,
    A_TXB  = 3'd2,
    A_RXD  = 3'd3,
    A_CTRL = 3'd4,
    A_DIV  = 3'd5,
    A_INTS = 3'd6
  } reg_addr_e;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_BITS
  } rx_state_e;
endpackage

// File: rtl/dbg_uart_baud.sv
module dbg_uart_baud #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim_m1;

  always_comb begin
    lim_m1 = (div == '0) ? '0 : div - 1'b1;
    tick   = (cnt_q >= lim_m1);
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dbg_uart_tx.sv
module dbg_uart_tx
  import dbg_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [BYTE_W-1:0] data,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              tx,
  output logic              busy,
  output logic              done
);
  logic [FRM_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0] sub_q, sub_d;
  logic [BIT_W-1:0] bit_q, bit_d, last;
  logic             busy_q, busy_d, par;

  always_comb begin
    par    = (^data) ^ par_odd;
    last   = par_en ? BIT_W'(FRM_W - 1) : BIT_W'(FRM_W - 2);
    sh_d   = sh_q;
    sub_d  = sub_q;
    bit_d  = bit_q;
    busy_d = busy_q;
    done   = 1'b0;
    if (!busy_q) begin
      if (load) begin
        busy_d = 1'b1;
        sh_d   = {1'b1, (par_en ? par : 1'b1), data, 1'b0};
        sub_d  = '0;
        bit_d  = '0;
      end
    end else if (tick) begin
      sub_d = sub_q + 1'b1;
      if (sub_q == CNT_W'(OVS - 1)) begin
        sh_d = {1'b1, sh_q[FRM_W-1:1]};
        if (bit_q == last) begin
          busy_d = 1'b0;
          done   = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      sub_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      sub_q  <= sub_d;
      bit_q  <= bit_d;
      busy_q <= busy_d;
    end
  end

  assign tx   = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;
endmodule

// File: rtl/dbg_uart_rx.sv
module dbg_uart_rx
  import dbg_uart_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [BYTE_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  localparam int SH_W = BYTE_W + 2;

  rx_state_e        st_q, st_d;
  logic             prev_q;
  logic [CNT_W-1:0] sub_q, sub_d;
  logic [BIT_W-1:0] bit_q, bit_d, last;
  logic [SH_W-1:0]  sh_q, sh_d, sh_nx;

  always_comb begin
    sh_nx = {rx, sh_q[SH_W-1:1]};
    data  = par_en ? sh_nx[BYTE_W-1:0] : sh_nx[BYTE_W:1];
    perr  = par_en && (sh_nx[BYTE_W] != ((^data) ^ par_odd));
    ferr  = !sh_nx[SH_W-1];
    last  = par_en ? BIT_W'(BYTE_W + 1) : BIT_W'(BYTE_W);
    st_d  = st_q;
    sub_d = sub_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    done  = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (prev_q && !rx) begin
          st_d  = RX_START;
          sub_d = '0;
        end
      end
      RX_START: begin
        if (tick) begin
          sub_d = sub_q + 1'b1;
          if (sub_q == CNT_W'(HALF - 1)) begin
            sub_d = '0;
            bit_d = '0;
            st_d  = rx ? RX_IDLE : RX_BITS;
          end
        end
      end
      RX_BITS: begin
        if (tick) begin
          sub_d = sub_q + 1'b1;
          if (sub_q == CNT_W'(OVS - 1)) begin
            sh_d = sh_nx;
            if (bit_q == last) begin
              done = 1'b1;
              st_d = RX_IDLE;
            end else begin
              bit_d = bit_q + 1'b1;
            end
          end
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      prev_q <= 1'b1;
      sub_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else begin
      st_q   <= st_d;
      prev_q <= rx;
      sub_q  <= sub_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
    end
  end
endmodule

// File: rtl/dbg_uart.sv
module dbg_uart
  import dbg_uart_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [REG_DW-1:0] bus_wdata,
  output logic [REG_DW-1:0] bus_rdata,
  input  logic              rx_in,
  output logic              tx_out,
  output logic              irq
);
  logic [1:0]        rs_q;
  logic              rst_i;
  logic [1:0]        rxs_q;
  logic              tick, tx_busy, tx_done, tx_load;
  logic              rx_done, rx_perr, rx_ferr;
  logic [BYTE_W-1:0] rx_data;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              pen_q, pen_d, podd_q, podd_d;
  logic [BYTE_W-1:0] buf_q, buf_d;
  logic              full_q, full_d;
  logic              pe_q, pe_d, fe_q, fe_d, ov_q, ov_d, int_q, int_d;
  logic              wr_stat, wr_tx, wr_ctrl, wr_div, wr_ints, rd_rx;

  // reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) rxs_q <= 2'b11;
    else        rxs_q <= {rxs_q[0], rx_in};
  end

  dbg_uart_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_i), .div(div_q), .tick(tick)
  );

  dbg_uart_tx u_tx (
    .clk(clk), .rst_n(rst_i), .tick(tick), .load(tx_load),
    .data(bus_wdata[BYTE_W-1:0]), .par_en(pen_q), .par_odd(podd_q),
    .tx(tx_out), .busy(tx_busy), .done(tx_done)
  );

  dbg_uart_rx u_rx (
    .clk(clk), .rst_n(rst_i), .tick(tick), .rx(rxs_q[1]),
    .par_en(pen_q), .par_odd(podd_q), .done(rx_done),
    .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
  );

  always_comb begin
    wr_stat = bus_sel && bus_wr && (bus_addr == A_STAT);
    wr_tx   = bus_sel && bus_wr && ((bus_addr == A_TXA) || (bus_addr == A_TXB));
    wr_ctrl = bus_sel && bus_wr && (bus_addr == A_CTRL);
    wr_div  = bus_sel && bus_wr && (bus_addr == A_DIV);
    wr_ints = bus_sel && bus_wr && (bus_addr == A_INTS);
    rd_rx   = bus_sel && !bus_wr && (bus_addr == A_RXD);
    tx_load = wr_tx && !tx_busy;

    div_d  = wr_div  ? bus_wdata[DIV_W-1:0] : div_q;
    pen_d  = wr_ctrl ? bus_wdata[0] : pen_q;
    podd_d = wr_ctrl ? bus_wdata[1] : podd_q;
    buf_d  = rx_done ? rx_data : buf_q;
    full_d = rx_done ? 1'b1 : (rd_rx ? 1'b0 : full_q);

    // a new event wins over a clear in the same cycle
    pe_d  = (pe_q  && !(wr_stat && bus_wdata[ST_PE])) || (rx_done && rx_perr);
    fe_d  = (fe_q  && !(wr_stat && bus_wdata[ST_FE])) || (rx_done && rx_ferr);
    ov_d  = (ov_q  && !(wr_stat && bus_wdata[ST_OV])) || (rx_done && full_q && !rd_rx);
    int_d = (int_q && !(wr_ints && bus_wdata[0]))     || tx_done;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      div_q  <= '0;
      pen_q  <= 1'b0;
      podd_q <= 1'b0;
      buf_q  <= '0;
      full_q <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      ov_q   <= 1'b0;
      int_q  <= 1'b0;
    end else begin
      div_q  <= div_d;
      pen_q  <= pen_d;
      podd_q <= podd_d;
      buf_q  <= buf_d;
      full_q <= full_d;
      pe_q   <= pe_d;
      fe_q   <= fe_d;
      ov_q   <= ov_d;
      int_q  <= int_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_STAT: begin
        bus_rdata[ST_BUSY] = tx_busy;
        bus_rdata[ST_PE]   = pe_q;
        bus_rdata[ST_FE]   = fe_q;
        bus_rdata[ST_OV]   = ov_q;
      end
      A_RXD:  bus_rdata[BYTE_W-1:0] = buf_q;
      A_CTRL: bus_rdata[1:0] = {podd_q, pen_q};
      A_DIV:  bus_rdata[DIV_W-1:0] = div_q;
      A_INTS: bus_rdata[0] = int_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = int_q;
endmodule

// File: rtl/dbg_uart_chk.sv
module dbg_uart_chk
  import dbg_uart_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [REG_DW-1:0] bus_wdata,
  input logic [REG_DW-1:0] bus_rdata,
  input logic              tx_out,
  input logic              irq,
  input logic              busy,
  input logic              pe,
  input logic              fe,
  input logic              ov
);
  logic rd_stat, wr_tx, wr_stat, wr_ints;
  assign rd_stat = bus_sel && !bus_wr && (bus_addr == A_STAT);
  assign wr_tx   = bus_sel && bus_wr && ((bus_addr == A_TXA) || (bus_addr == A_TXB));
  assign wr_stat = bus_sel && bus_wr && (bus_addr == A_STAT);
  assign wr_ints = bus_sel && bus_wr && (bus_addr == A_INTS);

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> (bus_rdata[15:8] == 8'h00 && bus_rdata[6:3] == 4'h0));

  a_r3_busy_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && !busy) |=> busy);

  a_r3_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_out);

  a_r4_done_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  a_r4_irq_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && wr_ints && bus_wdata[0] && !busy) |=> !irq);

  a_r10_pe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pe && !(wr_stat && bus_wdata[ST_PE])) |=> pe);

  a_r10_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fe && !(wr_stat && bus_wdata[ST_FE])) |=> fe);

  a_r10_ov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ov && !(wr_stat && bus_wdata[ST_OV])) |=> ov);
endmodule

bind dbg_uart dbg_uart_chk u_chk (
  .clk(clk), .rst_n(rst_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .tx_out(tx_out), .irq(irq), .busy(tx_busy), .pe(pe_q), .fe(fe_q), .ov(ov_q)
);

// File: tb/sim_dbg_uart.sv
`timescale 1ns/1ps
module sim_dbg_uart;
  import dbg_uart_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        rx_in = 1'b1;
  logic        tx_out, irq;

  int n_chk = 0, n_fail = 0;
  int per = 64;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dbg_uart u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_in(rx_in), .tx_out(tx_out), .irq(irq)
  );

  function automatic logic par_of(input logic [7:0] b, input logic odd);
    return (^b) ^ odd;
  endfunction

  function automatic logic [10:0] exp_frame(input logic [7:0] b, input logic pen, input logic odd);
    return pen ? {1'b1, par_of(b, odd), b, 1'b0} : {1'b0, 1'b1, b, 1'b0};
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic cap_tx(input int nb, output logic [10:0] f);
    f = '0;
    repeat (per / 2) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      f[i] = tx_out;
      repeat (per) @(negedge clk);
    end
  endtask

  task automatic send_rx(input logic [7:0] b, input logic pen, input logic odd,
                         input logic bad_par, input logic bad_stop);
    @(negedge clk);
    rx_in = 1'b0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_in = b[i];
      repeat (per) @(negedge clk);
    end
    if (pen) begin
      rx_in = par_of(b, odd) ^ bad_par;
      repeat (per) @(negedge clk);
    end
    rx_in = !bad_stop;
    repeat (per) @(negedge clk);
    rx_in = 1'b1;
    repeat (per) @(negedge clk);
  endtask

  // one transmit, checking busy, the frame and completion (R3, R4)
  task automatic tx_case(input logic [2:0] a, input logic [7:0] b, input logic pen, input logic odd);
    logic [15:0] d;
    logic [10:0] f, e;
    wr(a, {8'h00, b});
    rd(A_STAT, d);
    check(d[7] == 1'b1, "R3 busy after write", d, 16'h0080);
    cap_tx(pen ? 11 : 10, f);
    e = exp_frame(b, pen, odd);
    check(f == e, "R3 frame bits", {5'b0, f}, {5'b0, e});
    rd(A_STAT, d);
    check(d[7] == 1'b0, "R4 busy cleared", d, 16'h0000);
    rd(A_INTS, d);
    check(d == 16'h0001 && irq, "R4 done flag and irq", d, 16'h0001);
    wr(A_INTS, 16'h0001);
    #1 check(!irq, "R4 irq cleared by w1c", {15'b0, irq}, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [10:0] f, e;
    logic [7:0]  b, b2;
    logic        pen, odd;
    int          s;
    s = int'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    rd(A_STAT, d);
    check(d == 16'h0000, "R2 status after reset", d, 16'h0000);
    rd(A_INTS, d);
    check(d == 16'h0000 && !irq, "R2 int status after reset", d, 16'h0000);
    rd(A_RXD, d);
    check(d == 16'h0000, "R2 rx buffer after reset", d, 16'h0000);
    check(tx_out == 1'b1, "R2 line idle high", {15'b0, tx_out}, 16'h0001);

    wr(A_DIV, 16'd4);
    per = 64;

    // R3 via both transmit addresses, no parity
    tx_case(A_TXA, 8'hA5, 1'b0, 1'b0);
    tx_case(A_TXB, 8'h3C, 1'b0, 1'b0);

    // R7 even then odd parity on transmit
    wr(A_CTRL, 16'h0001);
    tx_case(A_TXA, 8'h81, 1'b1, 1'b0);
    wr(A_CTRL, 16'h0003);
    tx_case(A_TXB, 8'h80, 1'b1, 1'b1);
    wr(A_CTRL, 16'h0000);

    // R5 write while busy ignored
    wr(A_TXA, 16'h0055);
    wr(A_TXB, 16'h00F0);
    cap_tx(10, f);
    e = exp_frame(8'h55, 1'b0, 1'b0);
    check(f == e, "R5 in-flight byte unchanged", {5'b0, f}, {5'b0, e});
    repeat (3 * per) @(negedge clk);
    rd(A_STAT, d);
    check(d[7] == 1'b0 && tx_out, "R5 no second frame", d, 16'h0000);
    wr(A_INTS, 16'h0001);

    // R11 divisor 0 acts as 1
    wr(A_DIV, 16'd0);
    per = 16;
    wr(A_TXA, 16'h00C3);
    cap_tx(10, f);
    e = exp_frame(8'hC3, 1'b0, 1'b0);
    check(f == e, "R11 divisor zero bit period", {5'b0, f}, {5'b0, e});
    wr(A_INTS, 16'h0001);
    wr(A_DIV, 16'd4);
    per = 64;

    // R6 receive
    send_rx(8'h5A, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(A_RXD, d);
    check(d == 16'h005A, "R6 received byte", d, 16'h005A);
    rd(A_STAT, d);
    check(d == 16'h0000, "R6 clean frame no flags", d, 16'h0000);

    // R7 parity error
    wr(A_CTRL, 16'h0001);
    send_rx(8'h12, 1'b1, 1'b0, 1'b1, 1'b0);
    rd(A_STAT, d);
    check(d == 16'h0004, "R7 parity error flag", d, 16'h0004);
    rd(A_RXD, d);
    wr(A_STAT, 16'h0004);
    rd(A_STAT, d);
    check(d == 16'h0000, "R10 pe cleared by w1c", d, 16'h0000);
    wr(A_CTRL, 16'h0000);

    // R8 framing error, byte still stored
    send_rx(8'h77, 1'b0, 1'b0, 1'b0, 1'b1);
    rd(A_STAT, d);
    check(d == 16'h0002, "R8 framing error flag", d, 16'h0002);
    rd(A_RXD, d);
    check(d == 16'h0077, "R8 byte stored", d, 16'h0077);
    wr(A_STAT, 16'h0002);

    // R9 overrun, newer byte kept
    send_rx(8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
    send_rx(8'h22, 1'b0, 1'b0, 1'b0, 1'b0);
    rd(A_STAT, d);
    check(d == 16'h0001, "R9 overrun flag", d, 16'h0001);
    rd(A_RXD, d);
    check(d == 16'h0022, "R9 newer byte kept", d, 16'h0022);

    // R10 clearing other bits leaves overrun set
    wr(A_STAT, 16'h0006);
    rd(A_STAT, d);
    check(d == 16'h0001, "R10 overrun stays", d, 16'h0001);
    wr(A_STAT, 16'h0001);
    rd(A_STAT, d);
    check(d == 16'h0000, "R10 overrun cleared", d, 16'h0000);

    // R12 short glitch discarded
    @(negedge clk);
    rx_in = 1'b0;
    repeat (8) @(negedge clk);
    rx_in = 1'b1;
    repeat (20 * per) @(negedge clk);
    rd(A_RXD, d);
    check(d == 16'h0022, "R12 glitch no frame", d, 16'h0022);
    rd(A_STAT, d);
    check(d == 16'h0000, "R12 glitch no flags", d, 16'h0000);

    // random bytes and modes, both directions
    for (int i = 0; i < 6; i++) begin
      b   = 8'($urandom());
      b2  = 8'($urandom());
      pen = 1'($urandom());
      odd = 1'($urandom());
      wr(A_CTRL, {14'b0, odd, pen});
      tx_case(((i % 2) == 0) ? 3'(A_TXA) : 3'(A_TXB), b, pen, odd);
      send_rx(b2, pen, odd, 1'b0, 1'b0);
      rd(A_RXD, d);
      check(d == {8'h00, b2}, "R6 random receive", d, {8'h00, b2});
      rd(A_STAT, d);
      check(d == 16'h0000, "R7 random no parity error", d, 16'h0000);
    end

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule